// File: doc/BRIEF.md
# UART Flow Control Controller

This block decides when a UART may talk and when it asks its partner to stop talking. It compares the fill level of the receive FIFO against two programmable thresholds that form a hysteresis window: a high-water mark that stops the remote sender and a low-water mark that lets it resume. The result can drive the active-low RTS pin directly, or it can raise single-shot requests asking the transmitter to send an Xoff or Xon character in-band.

On the transmit side the block gates the start of new characters on the CTS input when CTS gating is enabled, so that a character already on the wire always finishes. For half-duplex RS-485 links, the block can also hand the RTS pin to the transmitter as a line-direction signal. RTS then stays asserted while data is pending or shifting and is released at the first baud tick after the transmitter goes idle. The RTS pin has three possible sources, and a fixed precedence decides which one drives it.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, rts_n is 1 and both xoff_req and xon_req are 0.
- R2: The stop threshold is thr_ctrl[3:0] times 4 and the resume threshold is thr_ctrl[7:4] times 4, both compared with rx_level. A field of 15 gives 60 and a field of 0 gives 0.
- R3: With auto_rts_en=1 and rs485_en=0, rts_n goes to 1 on the clock edge at which rx_level is at or above the stop threshold. While the block is not halted and rx_level stays below that threshold, rts_n is 0.
- R4: Once halted, rts_n stays 1 while rx_level lies strictly between the two thresholds. It returns to 0 on the edge at which rx_level is at or below the resume threshold.
- R5: With auto_rts_en=0 and rs485_en=0, rts_n takes the inverse of manual_rts on the next clock edge.
- R6: The RTS source precedence is rs485_en first, then auto_rts_en, then manual_rts.
- R7: With rs485_en=1, rts_n is 0 on the edge after tx_busy is seen high. After tx_busy falls, rts_n stays 0 until the first cycle with bit_tick=1, and goes to 1 on that edge.
- R8: With auto_cts_en=1, cts_n=1 and tx_shifting=0, tx_enable is 0. If tx_shifting=1 or cts_n=0, tx_enable is 1. With auto_cts_en=0, tx_enable is always 1.
- R9: With sw_flow_en=1, a crossing into the halted state sets xoff_req on that edge. xoff_req then holds until sw_ack is 1 or a resume crossing occurs.
- R10: With sw_flow_en=1, a resume crossing sets xon_req and clears any pending xoff_req, and the reverse holds for a stop crossing. xoff_req and xon_req are never 1 together.
- R11: Each crossing yields exactly one request. After sw_ack, no new request appears while rx_level stays on the same side of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | 7 | Characters currently held in the receive FIFO (0..64) |
| thr_ctrl | input | 8 | Stop threshold field [3:0], resume threshold field [7:4] |
| auto_rts_en | input | 1 | RTS follows the receive-level hysteresis |
| auto_cts_en | input | 1 | Gate new transmit characters on CTS |
| sw_flow_en | input | 1 | Raise Xoff/Xon requests on threshold crossings |
| manual_rts | input | 1 | Manual RTS: 1 asserts the pin (drives it low) |
| rs485_en | input | 1 | Transmitter owns RTS for line direction |
| cts_n | input | 1 | Clear-to-send, active low, synchronous to clk |
| tx_busy | input | 1 | Transmitter holds or shifts data |
| tx_shifting | input | 1 | A character is currently being shifted out |
| bit_tick | input | 1 | One-cycle baud bit tick |
| sw_ack | input | 1 | Transmitter has taken the pending Xon/Xoff request |
| rts_n | output | 1 | RTS pin, active low |
| tx_enable | output | 1 | Transmitter may start a new character |
| xoff_req | output | 1 | Request to send an Xoff character |
| xon_req | output | 1 | Request to send an Xon character |

## Verification
The bench builds the block with its default 64-entry FIFO depth, so the threshold scale is 4 and the level bus is 7 bits wide. That lets a level walk pass through both edges of the window and hit each edge exactly, landing one below, on and one above each threshold. The extremes of the 4-bit fields are also in reach: a stop threshold of 60 and a resume threshold of 0.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    localparam int unsigned FC_FIFO_DEPTH = 64;
    localparam int unsigned FC_FIELD_W    = 4;
    localparam int unsigned FC_LVL_W      = $clog2(FC_FIFO_DEPTH + 1);

    typedef enum logic [1:0] {
        DIR_IDLE   = 2'd0,
        DIR_ACTIVE = 2'd1,
        DIR_DRAIN  = 2'd2
    } dir_state_t;

    typedef struct packed {
        logic auto_rts;
        logic auto_cts;
        logic sw_flow;
        logic manual_rts;
        logic rs485;
    } fc_cfg_t;

    typedef struct packed {
        logic halted_q;
        logic halted_d;
        logic stop_evt;
        logic resume_evt;
    } fc_hyst_t;

endpackage

// File: rtl/fc_level_track.sv
module fc_level_track
    import uart_fc_pkg::*;
#(
    parameter int unsigned DEPTH   = FC_FIFO_DEPTH,
    parameter int unsigned FIELD_W = FC_FIELD_W,
    parameter int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [FIELD_W-1:0] stop_field,
    input  logic [FIELD_W-1:0] resume_field,
    output fc_hyst_t           hyst
);
    localparam int unsigned SCALE = DEPTH / (1 << FIELD_W);

    logic [LVL_W-1:0] stop_lvl;
    logic [LVL_W-1:0] resume_lvl;
    logic             halted_q;
    logic             halted_d;

    always_comb begin
        stop_lvl   = LVL_W'(int'(stop_field) * int'(SCALE));
        resume_lvl = LVL_W'(int'(resume_field) * int'(SCALE));
    end

    // stop mark wins if the window is programmed inverted
    always_comb begin
        if (rx_level >= stop_lvl)
            halted_d = 1'b1;
        else if (rx_level <= resume_lvl)
            halted_d = 1'b0;
        else
            halted_d = halted_q;
    end

    always_ff @(posedge clk) begin
        if (rst) halted_q <= 1'b0;
        else     halted_q <= halted_d;
    end

    always_comb begin
        hyst.halted_q   = halted_q;
        hyst.halted_d   = halted_d;
        hyst.stop_evt   = halted_d & ~halted_q;
        hyst.resume_evt = ~halted_d & halted_q;
    end

    // R3
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(halted_q) |-> $past(rx_level) >= $past(stop_lvl));

    // R4
    halt_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(halted_q) |-> $past(rx_level) <= $past(resume_lvl));

endmodule

// File: rtl/fc_sw_flow.sv
module fc_sw_flow
    import uart_fc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sw_en,
    input  fc_hyst_t hyst,
    input  logic     sw_ack,
    output logic     xoff_req,
    output logic     xon_req
);
    always_ff @(posedge clk) begin
        if (rst || !sw_en) begin
            xoff_req <= 1'b0;
            xon_req  <= 1'b0;
        end else if (hyst.stop_evt) begin
            xoff_req <= 1'b1;
            xon_req  <= 1'b0;
        end else if (hyst.resume_evt) begin
            xoff_req <= 1'b0;
            xon_req  <= 1'b1;
        end else if (sw_ack) begin
            xoff_req <= 1'b0;
            xon_req  <= 1'b0;
        end
    end

    // R10
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(xoff_req && xon_req));

    // R9
    xoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_en && xoff_req && !sw_ack && !hyst.resume_evt) |=> xoff_req);

    // R11
    xoff_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(xoff_req) |-> $past(hyst.stop_evt));

endmodule

// File: rtl/fc_rs485_dir.sv
module fc_rs485_dir
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_busy,
    input  logic bit_tick,
    output logic dir_on
);
    dir_state_t state_q;
    dir_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_IDLE:   if (tx_busy) state_d = DIR_ACTIVE;
            DIR_ACTIVE: if (!tx_busy) state_d = DIR_DRAIN;
            DIR_DRAIN: begin
                if (tx_busy)       state_d = DIR_ACTIVE;
                else if (bit_tick) state_d = DIR_IDLE;
            end
            default:    state_d = DIR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DIR_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        dir_on = tx_busy || (state_q == DIR_ACTIVE) ||
                 ((state_q == DIR_DRAIN) && !bit_tick);
    end

    // R7
    drain_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == DIR_DRAIN) && !tx_busy && !bit_tick |=> state_q == DIR_DRAIN);

endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate (
    input  logic cts_gate_en,
    input  logic cts_n,
    input  logic tx_shifting,
    output logic tx_enable
);
    always_comb begin
        tx_enable = tx_shifting || !(cts_gate_en && cts_n);
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int unsigned DEPTH   = FC_FIFO_DEPTH,
    parameter int unsigned FIELD_W = FC_FIELD_W,
    parameter int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LVL_W-1:0]     rx_level,
    input  logic [2*FIELD_W-1:0] thr_ctrl,
    input  logic                 auto_rts_en,
    input  logic                 auto_cts_en,
    input  logic                 sw_flow_en,
    input  logic                 manual_rts,
    input  logic                 rs485_en,
    input  logic                 cts_n,
    input  logic                 tx_busy,
    input  logic                 tx_shifting,
    input  logic                 bit_tick,
    input  logic                 sw_ack,
    output logic                 rts_n,
    output logic                 tx_enable,
    output logic                 xoff_req,
    output logic                 xon_req
);
    fc_cfg_t  cfg;
    fc_hyst_t hyst;
    logic     dir_on;
    logic     rts_d;
    logic     rts_q;

    always_comb begin
        cfg.auto_rts   = auto_rts_en;
        cfg.auto_cts   = auto_cts_en;
        cfg.sw_flow    = sw_flow_en;
        cfg.manual_rts = manual_rts;
        cfg.rs485      = rs485_en;
    end

    fc_level_track #(
        .DEPTH   (DEPTH),
        .FIELD_W (FIELD_W),
        .LVL_W   (LVL_W)
    ) i_track (
        .clk          (clk),
        .rst          (rst),
        .rx_level     (rx_level),
        .stop_field   (thr_ctrl[FIELD_W-1:0]),
        .resume_field (thr_ctrl[2*FIELD_W-1:FIELD_W]),
        .hyst         (hyst)
    );

    fc_sw_flow i_sw (
        .clk      (clk),
        .rst      (rst),
        .sw_en    (cfg.sw_flow),
        .hyst     (hyst),
        .sw_ack   (sw_ack),
        .xoff_req (xoff_req),
        .xon_req  (xon_req)
    );

    fc_rs485_dir i_dir (
        .clk      (clk),
        .rst      (rst),
        .tx_busy  (tx_busy),
        .bit_tick (bit_tick),
        .dir_on   (dir_on)
    );

    fc_cts_gate i_cts (
        .cts_gate_en (cfg.auto_cts),
        .cts_n       (cts_n),
        .tx_shifting (tx_shifting),
        .tx_enable   (tx_enable)
    );

    // fixed precedence: direction control, then hysteresis, then manual bit
    always_comb begin
        if (cfg.rs485)         rts_d = ~dir_on;
        else if (cfg.auto_rts) rts_d = hyst.halted_d;
        else                   rts_d = ~cfg.manual_rts;
    end

    always_ff @(posedge clk) begin
        if (rst) rts_q <= 1'b1;
        else     rts_q <= rts_d;
    end

    assign rts_n = rts_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (rts_n && !xoff_req && !xon_req));

    // R7
    rs485_assert_chk: assert property (@(posedge clk) disable iff (rst)
        (rs485_en && tx_busy) |=> !rts_n);

    // R7
    rs485_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rs485_en) && $rose(rts_n)) |-> $past(bit_tick));

    // R5
    manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!rs485_en && !auto_rts_en) |=> (rts_n == !$past(manual_rts)));

endmodule

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] rx_level;
    logic [7:0] thr_ctrl;
    logic       auto_rts_en, auto_cts_en, sw_flow_en, manual_rts, rs485_en;
    logic       cts_n, tx_busy, tx_shifting, bit_tick, sw_ack;
    logic       rts_n, tx_enable, xoff_req, xon_req;

    int tests_run = 0;
    int tests_failed = 0;

    always #5 clk = ~clk;

    uart_flow_ctrl i_uart_flow_ctrl (
        .clk(clk), .rst(rst), .rx_level(rx_level), .thr_ctrl(thr_ctrl),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .sw_flow_en(sw_flow_en), .manual_rts(manual_rts), .rs485_en(rs485_en),
        .cts_n(cts_n), .tx_busy(tx_busy), .tx_shifting(tx_shifting),
        .bit_tick(bit_tick), .sw_ack(sw_ack), .rts_n(rts_n),
        .tx_enable(tx_enable), .xoff_req(xoff_req), .xon_req(xon_req)
    );

    // {level[6:0], rts_n, xoff_req, xon_req}; window stop 32, resume 16
    localparam logic [9:0] VEC [12] = '{
        {7'd10, 1'b0, 1'b0, 1'b0},
        {7'd31, 1'b0, 1'b0, 1'b0},
        {7'd32, 1'b1, 1'b1, 1'b0},
        {7'd40, 1'b1, 1'b1, 1'b0},
        {7'd20, 1'b1, 1'b1, 1'b0},
        {7'd17, 1'b1, 1'b1, 1'b0},
        {7'd16, 1'b0, 1'b0, 1'b1},
        {7'd25, 1'b0, 1'b0, 1'b1},
        {7'd31, 1'b0, 1'b0, 1'b1},
        {7'd33, 1'b1, 1'b1, 1'b0},
        {7'd16, 1'b0, 1'b0, 1'b1},
        {7'd0,  1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #100us;
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_level = '0; thr_ctrl = 8'h48;
        auto_rts_en = 0; auto_cts_en = 0; sw_flow_en = 0; manual_rts = 0;
        rs485_en = 0; cts_n = 0; tx_busy = 0; tx_shifting = 0; bit_tick = 0; sw_ack = 0;
        tick(); tick();
        chk("R1 rts_n in reset", rts_n, 1'b1);
        rst = 1'b0;
        tick();
        chk("R1 rts_n after reset", rts_n, 1'b1);
        chk("R1 xoff_req after reset", xoff_req, 1'b0);
        chk("R1 xon_req after reset", xon_req, 1'b0);

        // R3 R4 R9 R10 table walk
        auto_rts_en = 1; sw_flow_en = 1;
        for (int i = 0; i < 12; i++) begin
            rx_level = VEC[i][9:3];
            tick();
            chk($sformatf("R3/R4 rts_n vec%0d", i), rts_n, VEC[i][2]);
            chk($sformatf("R9 xoff_req vec%0d", i), xoff_req, VEC[i][1]);
            chk($sformatf("R10 xon_req vec%0d", i), xon_req, VEC[i][0]);
        end

        // R9 R11 acknowledge and single request
        sw_ack = 1; tick(); sw_ack = 0;
        chk("R10 xon cleared by ack", xon_req, 1'b0);
        rx_level = 7'd40; tick();
        chk("R9 xoff on stop crossing", xoff_req, 1'b1);
        tick(); tick();
        chk("R9 xoff held without ack", xoff_req, 1'b1);
        sw_ack = 1; tick(); sw_ack = 0;
        chk("R9 xoff cleared by ack", xoff_req, 1'b0);
        rx_level = 7'd50; tick(); tick();
        chk("R11 no second xoff", xoff_req, 1'b0);
        chk("R11 no xon while halted", xon_req, 1'b0);

        // R6 auto beats manual while halted
        manual_rts = 1; tick();
        chk("R6 auto over manual", rts_n, 1'b1);

        // R5 manual control
        auto_rts_en = 0; tick();
        chk("R5 manual 1 asserts", rts_n, 1'b0);
        manual_rts = 0; tick();
        chk("R5 manual 0 releases", rts_n, 1'b1);

        // R6 R7 rs485 over auto (still halted)
        auto_rts_en = 1; manual_rts = 0; tick();
        chk("R6 halted high", rts_n, 1'b1);
        rs485_en = 1; tx_busy = 1; tick();
        chk("R6/R7 rs485 over auto", rts_n, 1'b0);
        tx_busy = 0; tick(); tick(); tick();
        chk("R7 held after busy drop", rts_n, 1'b0);
        bit_tick = 1; tick(); bit_tick = 0;
        chk("R7 released at tick", rts_n, 1'b1);
        tick();
        chk("R7 stays released", rts_n, 1'b1);
        rs485_en = 0;

        // R2 boundaries: stop 60, resume 0
        sw_flow_en = 0; rx_level = 7'd0; tick();
        chk("R4 release at level 0", rts_n, 1'b0);
        thr_ctrl = 8'h0F; rx_level = 7'd59; tick();
        chk("R2 stop 60 not reached", rts_n, 1'b0);
        rx_level = 7'd60; tick();
        chk("R2 stop 60 reached", rts_n, 1'b1);
        rx_level = 7'd1; tick();
        chk("R2 resume 0 not reached", rts_n, 1'b1);
        rx_level = 7'd0; tick();
        chk("R2 resume 0 reached", rts_n, 1'b0);

        // R8 CTS gating
        auto_cts_en = 0; cts_n = 1; #1;
        chk("R8 gate off", tx_enable, 1'b1);
        auto_cts_en = 1; #1;
        chk("R8 cts high blocks", tx_enable, 1'b0);
        tx_shifting = 1; #1;
        chk("R8 shifting completes", tx_enable, 1'b1);
        tx_shifting = 0; cts_n = 0; #1;
        chk("R8 cts low allows", tx_enable, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule